// File: doc/BRIEF.md
# Memory Block Copy and Search Sequencer

This block moves or scans a run of bytes in memory under the control of three 16-bit registers: a source pointer, a destination pointer and a byte count. A command picks copy or compare, an incrementing or decrementing walk, and either one step or repeat mode. A copy reads a byte at the source pointer and writes it to the destination pointer. A compare reads a byte at the source pointer and tests it against an 8-bit key. When the command ends, the block shows the updated registers, four status flags (zero, parity/overflow, half-carry, subtract) and a one-cycle done pulse.

Memory is reached through one synchronous request port. `mem_rd` and `mem_wr` act as the valid side and `mem_ready` as the ready side. Once a strobe is raised, the strobe, the address and the write data stay constant until the memory answers with `mem_ready` high on a clock edge. The memory can hold off the engine for any number of cycles by keeping `mem_ready` low. Read data is taken on the edge where the read handshake completes.

Top module: `blkeng_top`

## Requirements
- R1: After reset the engine is idle with `busy`, `done`, `mem_rd` and `mem_wr` low, and all pointer and count registers and all flags are zero.
- R2: A `start` pulse is taken only while `busy` is low. It loads the source, destination, count and key registers and the command bits `cmd_cmp` (1 = compare, 0 = copy), `cmd_dec` (1 = decrement, 0 = increment) and `cmd_rep` (1 = repeat). A `start` that arrives while busy has no effect on the running command or its results.
- R3: Only one access is outstanding at any time. A raised strobe keeps its strobe, address and data until `mem_ready` is seen. The write of a copy step starts only after the read of the same step has completed.
- R4: A copy step reads the byte at the source pointer and writes it to the destination pointer. It then moves both pointers by +1, or by -1 in decrement mode, and decreases the count by one.
- R5: A repeating copy keeps issuing steps until the count is zero.
- R6: A compare step reads the byte at the source pointer and moves only the source pointer in the chosen direction. It decreases the count, issues no write and leaves the destination pointer unchanged. The zero flag is set when the byte equals the key and cleared otherwise.
- R7: A repeating compare stops after the first step that either finds a match or brings the count to zero.
- R8: After every command the parity/overflow flag is 1 if the count is non-zero and 0 if it is zero.
- R9: A copy clears the half-carry and subtract flags and leaves the zero flag as it was. A compare sets the subtract flag and sets half-carry when the key's low nibble is less than the byte's low nibble (a borrow out of bit 3 of key minus byte).
- R10: A starting count of zero wraps to 0xFFFF on the first step, so a repeating command runs for 65536 steps unless a compare match ends it earlier.
- R11: `done` is high for exactly one cycle. On that cycle the registers and flags hold their final values, and `busy` is low on the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a command when idle |
| cmd_cmp | input | 1 | 1 = compare, 0 = copy |
| cmd_dec | input | 1 | 1 = pointers decrease |
| cmd_rep | input | 1 | 1 = repeat mode |
| src_in | input | 16 | Initial source pointer |
| dst_in | input | 16 | Initial destination pointer |
| cnt_in | input | 16 | Initial byte count |
| key_in | input | 8 | Compare key |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| src_q | output | 16 | Current source pointer |
| dst_q | output | 16 | Current destination pointer |
| cnt_q | output | 16 | Current count |
| flag_z | output | 1 | Zero flag |
| flag_pv | output | 1 | Parity/overflow flag |
| flag_h | output | 1 | Half-carry flag |
| flag_n | output | 1 | Subtract flag |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read request (valid) |
| mem_wr | output | 1 | Write request (valid) |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, taken when the read completes |
| mem_ready | input | 1 | Memory accepts the current request |

## Verification
The assertions check the memory port rules on every cycle. No read and write are ever raised together, a stalled request holds its address, a write opens only right after a completed read, and no strobe is raised while idle. They also check that done is a single-cycle pulse followed by idle, and that parity/overflow on done matches whether the count is non-zero. Other properties appear only across whole scenarios: the final pointer values, the memory contents after copies, stopping on a match, the flag values that depend on the data, wrap-around of a zero count, and start pulses ignored while busy. The bench shows these by running random commands under random ready back-pressure against its own model.

// File: rtl/blkeng_pkg.sv
package blkeng_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_WRITE = 2'd2,
    ST_FIN  = 2'd3
  } blkeng_state_t;
endpackage

// File: rtl/blkeng_step.sv
module blkeng_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic         dec,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] ONE = W'(1);
  assign nxt = dec ? (val - ONE) : (val + ONE);
endmodule

// File: rtl/blkeng_cmp.sv
module blkeng_cmp #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] key,
  input  logic [DW-1:0] data,
  output logic          match,
  output logic          half_borrow
);
  localparam int HALF = DW / 2;
  assign match       = (key == data);
  assign half_borrow = (key[HALF-1:0] < data[HALF-1:0]);
endmodule

// File: rtl/blkeng_ctrl.sv
module blkeng_ctrl
  import blkeng_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic is_cmp,
  input  logic go_on,
  input  logic mem_ready,
  output logic load,
  output logic capture,
  output logic adv_copy,
  output logic adv_cmp,
  output logic rd,
  output logic wr,
  output logic busy,
  output logic done
);
  blkeng_state_t st, st_nx;

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  always_comb begin
    st_nx    = st;
    load     = 1'b0;
    capture  = 1'b0;
    adv_copy = 1'b0;
    adv_cmp  = 1'b0;
    rd       = 1'b0;
    wr       = 1'b0;
    done     = 1'b0;
    case (st)
      ST_IDLE: if (start) begin
        load  = 1'b1;
        st_nx = ST_READ;
      end
      ST_READ: begin
        rd = 1'b1;
        if (mem_ready) begin
          if (is_cmp) begin
            adv_cmp = 1'b1;
            st_nx   = go_on ? ST_READ : ST_FIN;
          end else begin
            capture = 1'b1;
            st_nx   = ST_WRITE;
          end
        end
      end
      ST_WRITE: begin
        wr = 1'b1;
        if (mem_ready) begin
          adv_copy = 1'b1;
          st_nx    = go_on ? ST_READ : ST_FIN;
        end
      end
      default: begin
        done  = 1'b1;
        st_nx = ST_IDLE;
      end
    endcase
  end

  assign busy = (st != ST_IDLE);
endmodule

// File: rtl/blkeng_top.sv
module blkeng_top #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cmd_cmp,
  input  logic          cmd_dec,
  input  logic          cmd_rep,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] dst_in,
  input  logic [AW-1:0] cnt_in,
  input  logic [DW-1:0] key_in,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [AW-1:0] cnt_q,
  output logic          flag_z,
  output logic          flag_pv,
  output logic          flag_h,
  output logic          flag_n,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic          cmp_q, dec_q, rep_q;
  logic [DW-1:0] key_q, rbuf_q;
  logic [AW-1:0] src_nx, dst_nx, cnt_nx;
  logic          match, hb, go_on;
  logic          load, capture, adv_copy, adv_cmp;

  blkeng_step #(.W(AW)) u_src_step (.val(src_q), .dec(dec_q), .nxt(src_nx));
  blkeng_step #(.W(AW)) u_dst_step (.val(dst_q), .dec(dec_q), .nxt(dst_nx));
  blkeng_cmp  #(.DW(DW)) u_cmp (.key(key_q), .data(mem_rdata), .match(match), .half_borrow(hb));

  assign cnt_nx = cnt_q - ONE;
  assign go_on  = rep_q && (cnt_nx != '0) && !(cmp_q && match);

  blkeng_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .is_cmp(cmp_q), .go_on(go_on),
    .mem_ready(mem_ready), .load(load), .capture(capture), .adv_copy(adv_copy),
    .adv_cmp(adv_cmp), .rd(mem_rd), .wr(mem_wr), .busy(busy), .done(done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0; dst_q <= '0; cnt_q <= '0; key_q <= '0; rbuf_q <= '0;
      cmp_q <= 1'b0; dec_q <= 1'b0; rep_q <= 1'b0;
      flag_z <= 1'b0; flag_pv <= 1'b0; flag_h <= 1'b0; flag_n <= 1'b0;
    end else begin
      if (load) begin
        src_q <= src_in; dst_q <= dst_in; cnt_q <= cnt_in; key_q <= key_in;
        cmp_q <= cmd_cmp; dec_q <= cmd_dec; rep_q <= cmd_rep;
      end
      if (capture) rbuf_q <= mem_rdata;
      if (adv_copy) begin
        src_q   <= src_nx;
        dst_q   <= dst_nx;
        cnt_q   <= cnt_nx;
        flag_pv <= (cnt_nx != '0);
        flag_h  <= 1'b0;
        flag_n  <= 1'b0;
      end
      if (adv_cmp) begin
        src_q   <= src_nx;
        cnt_q   <= cnt_nx;
        flag_z  <= match;
        flag_pv <= (cnt_nx != '0);
        flag_h  <= hb;
        flag_n  <= 1'b1;
      end
    end
  end

  assign mem_addr  = mem_wr ? dst_q : src_q;
  assign mem_wdata = rbuf_q;
endmodule

// File: rtl/blkeng_chk.sv
module blkeng_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] cnt_q,
  input logic          flag_pv
);
  p_one_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_hold_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && !mem_ready) |=> ($stable(mem_rd) && $stable(mem_wr) && $stable(mem_addr)));

  p_write_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr) |-> $past(mem_rd && mem_ready));

  p_quiet_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr));

  p_pv_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_pv == (cnt_q != '0)));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
endmodule

bind blkeng_top blkeng_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_rd(mem_rd),
  .mem_wr(mem_wr), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .cnt_q(cnt_q), .flag_pv(flag_pv)
);

// File: tb/blkeng_top_tb_top.sv
module blkeng_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, cmd_cmp = 1'b0, cmd_dec = 1'b0, cmd_rep = 1'b0;
  logic [15:0] src_in = '0, dst_in = '0, cnt_in = '0;
  logic [7:0]  key_in = '0;
  logic busy, done, flag_z, flag_pv, flag_h, flag_n, mem_rd, mem_wr;
  logic [15:0] src_q, dst_q, cnt_q, mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic mem_ready = 1'b0;

  logic [7:0] mem [256];
  logic [7:0] emem [256];
  logic [15:0] e_src, e_dst, e_cnt;
  logic e_z = 1'b0, e_pv, e_h, e_n;
  int tests = 0, fails = 0, cycles = 0;
  int ready_pct = 60;

  always #2 clk = ~clk;

  blkeng_top dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_cmp(cmd_cmp), .cmd_dec(cmd_dec),
    .cmd_rep(cmd_rep), .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in), .key_in(key_in),
    .busy(busy), .done(done), .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q),
    .flag_z(flag_z), .flag_pv(flag_pv), .flag_h(flag_h), .flag_n(flag_n),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_wr && mem_ready) mem[mem_addr[7:0]] <= mem_wdata;
  always @(negedge clk) begin
    mem_ready <= (($urandom % 100) < ready_pct);
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic cmp, input logic dec, input logic rep,
                       input logic [15:0] s, input logic [15:0] d, input logic [15:0] c,
                       input logic [7:0] k);
    logic m;
    logic [7:0] b;
    e_src = s; e_dst = d; e_cnt = c;
    forever begin
      m = 1'b0;
      if (cmp) begin
        b = emem[e_src[7:0]];
        m = (b == k);
        e_z = m;
        e_h = (k[3:0] < b[3:0]);
        e_n = 1'b1;
        e_src = dec ? e_src - 16'd1 : e_src + 16'd1;
      end else begin
        emem[e_dst[7:0]] = emem[e_src[7:0]];
        e_h = 1'b0; e_n = 1'b0;
        e_src = dec ? e_src - 16'd1 : e_src + 16'd1;
        e_dst = dec ? e_dst - 16'd1 : e_dst + 16'd1;
      end
      e_cnt = e_cnt - 16'd1;
      e_pv = (e_cnt != 16'd0);
      if (!(rep && e_cnt != 16'd0 && !m)) break;
    end
  endtask

  task automatic run(input logic cmp, input logic dec, input logic rep,
                     input logic [15:0] s, input logic [15:0] d, input logic [15:0] c,
                     input logic [7:0] k, input bit poke);
    string tag;
    tag = cmp ? (rep ? "R7" : "R6") : (rep ? "R5" : "R4");
    for (int i = 0; i < 256; i++) emem[i] = mem[i];
    model(cmp, dec, rep, s, d, c, k);
    @(negedge clk);
    start = 1'b1; cmd_cmp = cmp; cmd_dec = dec; cmd_rep = rep;
    src_in = s; dst_in = d; cnt_in = c; key_in = k;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R2: a second start while busy must change nothing
      @(negedge clk);
      start = 1'b1; cmd_cmp = ~cmp; cmd_dec = ~dec; cmd_rep = 1'b0;
      src_in = 16'h00F0; dst_in = 16'h0010; cnt_in = 16'd1; key_in = ~k;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk({tag, " src"}, 32'(src_q), 32'(e_src));
    chk({tag, " dst"}, 32'(dst_q), 32'(e_dst));
    chk({tag, " cnt"}, 32'(cnt_q), 32'(e_cnt));
    chk("R8 pv", 32'(flag_pv), 32'(e_pv));
    chk("R9 z", 32'(flag_z), 32'(e_z));
    chk("R9 h", 32'(flag_h), 32'(e_h));
    chk("R9 n", 32'(flag_n), 32'(e_n));
    if (!cmp) for (int i = 0; i < 256; i++) if (mem[i] !== emem[i]) chk("R4 mem", 32'(mem[i]), 32'(emem[i]));
    @(negedge clk);
    chk("R11 done one cycle", 32'({done, busy}), 32'(0));
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy/done/strobes", 32'({busy, done, mem_rd, mem_wr}), 32'(0));
    chk("R1 regs", 32'({src_q, dst_q} | 32'(cnt_q)), 32'(0));
    chk("R1 flags", 32'({flag_z, flag_pv, flag_h, flag_n}), 32'(0));
    rst_n = 1'b1;
    // directed corner cases
    run(1'b0, 1'b0, 1'b0, 16'h0010, 16'h0080, 16'd5, 8'h00, 1'b0);   // R4 single copy inc
    run(1'b0, 1'b1, 1'b0, 16'h0020, 16'h0090, 16'd1, 8'h00, 1'b0);   // R4 dec, count to zero
    run(1'b0, 1'b0, 1'b1, 16'h0000, 16'h00A0, 16'd20, 8'h00, 1'b0);  // R5 repeat copy
    mem[8'h45] = 8'h5A;
    mem[8'h46] = 8'h5A;
    for (int i = 8'h40; i < 8'h45; i++) if (mem[i] == 8'h5A) mem[i] = 8'h00;
    run(1'b1, 1'b0, 1'b1, 16'h0040, 16'h0000, 16'd30, 8'h5A, 1'b0);  // R7 stops at match
    run(1'b1, 1'b0, 1'b1, 16'h0040, 16'h0000, 16'd3, 8'h5A, 1'b0);   // R7 stops at zero count
    run(1'b1, 1'b0, 1'b0, 16'h0041, 16'h0000, 16'd0, 8'h5A, 1'b0);   // R10 single step wraps
    run(1'b1, 1'b1, 1'b1, 16'h004A, 16'h0000, 16'd0, 8'h5A, 1'b0);   // R10 repeat with zero count
    mem[8'h30] = 8'h3F;
    run(1'b1, 1'b0, 1'b0, 16'h0030, 16'h0000, 16'd9, 8'h21, 1'b0);   // R9 half borrow set
    run(1'b0, 1'b0, 1'b1, 16'h0050, 16'h0060, 16'd12, 8'h00, 1'b1);  // R2 start ignored while busy
    ready_pct = 100;
    run(1'b0, 1'b1, 1'b1, 16'h00FF, 16'h0070, 16'd8, 8'h00, 1'b0);   // R3 no stall
    ready_pct = 25;
    run(1'b0, 1'b0, 1'b1, 16'h00F8, 16'h0004, 16'd16, 8'h00, 1'b0);  // R3 heavy stalls, wrap of low byte
    ready_pct = 60;
    // random mix
    for (int n = 0; n < 60; n++) begin
      logic c, dd, r;
      logic [15:0] cn;
      c = 1'($urandom); dd = 1'($urandom); r = 1'($urandom);
      cn = r ? 16'(1 + $urandom % 40) : 16'($urandom);
      run(c, dd, r, 16'($urandom), 16'($urandom), cn, 8'($urandom % 8), 1'b0);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule